// File: doc/BRIEF.md
# Tagged Fan-In Pipeline with Routed Fan-Out

This block lets several requesters share one fixed-latency compute pipeline. Each of `NP` request ports offers an operation (two operands and a two-bit opcode) under a valid/ready handshake. A round-robin arbiter admits at most one operation per cycle. The operation is stamped with the number of the port that won, and that stamp stays with the work through every register stage. At the far end the stamp decides which of the `NP` result ports presents the result.

The datapath stands in for a real execution unit. It has one operand-capture stage, one compute-and-register stage and one output register, so results come back three clock edges after acceptance when nothing stalls. Each request port can also withdraw its own outstanding work. An operation accepted with its mask bit set can be cancelled by that port's stop line while it is still in the first two stages. Once it reaches the output register it is committed.

Top module: `tagged_merge_pipe`

## Requirements
- R1: During and immediately after synchronous reset every `out_valid` bit is low, and the arbiter starts its search at port 0, so the first grant goes to the lowest-numbered requesting port.
- R2: A bit of `in_ready` is high only while the same bit of `in_valid` is high, and at most one bit of `in_ready` is high in any cycle. An operation transfers only on an edge where its valid and ready are both high.
- R3: The grant goes to the first requesting port found by searching upward, with wraparound, from a pointer. After each grant the pointer moves to the winner's index plus one, modulo `NP`.
- R4: The result is computed modulo 2^`DW` from the opcode: 0 gives a+b, 1 gives a-b, 2 gives a XOR b, 3 gives a AND b.
- R5: With no stall, an operation accepted on edge e is offered from edge e+2 and transfers on edge e+3 if that port's `out_ready` is high. One operation can be accepted on every edge.
- R6: A result is offered only on the result port whose index equals the index of the request port that supplied it. While `out_valid[k]` is high, the tag slice k of `out_tag` equals k.
- R7: While the output register holds a result whose port has `out_ready` low, the whole pipeline freezes. No `in_ready` bit is high, and that port's `out_valid` and `out_z` hold steady until it is taken.
- R8: Every accepted operation that is not cancelled produces exactly one result. The results of one port leave in acceptance order.
- R9: A high `in_stop[k]` discards, without any output, every operation from port k that was accepted with `in_mask` high and is held in the first or second stage in that cycle. This applies while stalled as well. It also discards a masked operation from port k that is accepted in the same cycle.
- R10: A stop leaves untouched the operations accepted with `in_mask` low, the operations of other ports, and the result already in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NP | Per-port request valid |
| in_ready | output | NP | Per-port accept (arbiter grant) |
| in_a | input | NP*DW | Operand a, slice k belongs to port k |
| in_b | input | NP*DW | Operand b, slice k belongs to port k |
| in_op | input | NP*2 | Opcode, slice k belongs to port k |
| in_mask | input | NP | Marks the offered operation as cancellable |
| in_stop | input | NP | Per-port cancel of masked in-flight work |
| out_valid | output | NP | Per-port result valid |
| out_ready | input | NP | Per-port result accept |
| out_z | output | NP*DW | Result, slice k for port k |
| out_tag | output | NP*IDW | Origin tag, slice k for port k |

## Verification
An operation accepted on edge e is due as a transfer on edge e+3 whenever the run has no stall. The bench samples 3 ns after each falling edge, before the next rising edge. For each accepted operation it stores the expected value and the edge number, then compares the edge of each result transfer against that stamp plus three. In stall phases the edge comparison is switched off. There the bench checks instead that no request is granted and that the held result does not move. Cancellation phases are scored by counting transfers per port after the pipeline has drained.

// File: rtl/tfp_pkg.sv
`timescale 1ns/1ps
package tfp_pkg;
  localparam int OPW = 2;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XOR = 2'd2,
    OP_AND = 2'd3
  } tfp_op_e;
endpackage

// File: rtl/tfp_rr_arb.sv
`timescale 1ns/1ps
module tfp_rr_arb #(
  parameter int NP  = 3,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [NP-1:0]  req,
  output logic [NP-1:0]  gnt,
  output logic           any,
  output logic [IDW-1:0] idx
);
  logic [IDW-1:0] ptr;

  // search upward from the pointer, wrapping once
  always_comb begin
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int off = 0; off < NP; off++) begin
      int c;
      c = int'(ptr) + off;
      if (c >= NP) c = c - NP;
      if (en && !any && req[c]) begin
        any    = 1'b1;
        gnt[c] = 1'b1;
        idx    = IDW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (any) begin
      if (idx == IDW'(NP - 1)) ptr <= '0;
      else                     ptr <= idx + 1'b1;
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R2
  AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0); // R2
  AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < NP); // R3
  AST_PTR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (en && req[ptr]) |-> gnt[ptr]); // R3
endmodule

// File: rtl/tfp_alu.sv
`timescale 1ns/1ps
module tfp_alu import tfp_pkg::*; #(
  parameter int DW = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic [DW-1:0]  z
);
  tfp_op_e code;
  assign code = tfp_op_e'(op);

  always_comb begin
    case (code)
      OP_ADD:  z = a + b;
      OP_SUB:  z = a - b;
      OP_XOR:  z = a ^ b;
      default: z = a & b;
    endcase
  end
endmodule

// File: rtl/tfp_stage.sv
`timescale 1ns/1ps
module tfp_stage #(
  parameter int NP  = 3,
  parameter int IDW = 2,
  parameter int PW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [NP-1:0]  stop,
  input  logic           in_live,
  input  logic [IDW-1:0] in_tag,
  input  logic           in_mask,
  input  logic [PW-1:0]  in_pay,
  output logic           live,
  output logic [IDW-1:0] tag,
  output logic           mask,
  output logic [PW-1:0]  pay
);
  logic v;
  logic hit;
  logic kill;

  // stop line of the port that owns the held entry
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NP; k++) begin
      if (tag == IDW'(k)) hit = stop[k];
    end
  end

  assign kill = v && mask && hit;
  assign live = v && !kill;

  always_ff @(posedge clk) begin
    if (rst)     v <= 1'b0;
    else if (en) v <= in_live;
    else         v <= live;
  end

  // payload registers without reset so they map onto plain flops
  always_ff @(posedge clk) begin
    if (en) begin
      tag  <= in_tag;
      mask <= in_mask;
      pay  <= in_pay;
    end
  end

  AST_KILL_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (kill && !en) |=> !v); // R9
  AST_STALL_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!en && live) |=> (v && $stable(pay) && $stable(tag))); // R7
endmodule

// File: rtl/tagged_merge_pipe.sv
`timescale 1ns/1ps
module tagged_merge_pipe import tfp_pkg::*; #(
  parameter int NP  = 3,
  parameter int DW  = 8,
  parameter int IDW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NP-1:0]     in_valid,
  output logic [NP-1:0]     in_ready,
  input  logic [NP*DW-1:0]  in_a,
  input  logic [NP*DW-1:0]  in_b,
  input  logic [NP*OPW-1:0] in_op,
  input  logic [NP-1:0]     in_mask,
  input  logic [NP-1:0]     in_stop,
  output logic [NP-1:0]     out_valid,
  input  logic [NP-1:0]     out_ready,
  output logic [NP*DW-1:0]  out_z,
  output logic [NP*IDW-1:0] out_tag
);
  localparam int PW0 = OPW + 2 * DW;

  logic           adv;
  logic [NP-1:0]  gnt;
  logic           gnt_any;
  logic [IDW-1:0] gnt_idx;

  logic [DW-1:0]  sel_a, sel_b;
  logic [OPW-1:0] sel_op;
  logic           sel_mask, sel_stop;

  logic           s0_live, s0_mask;
  logic [IDW-1:0] s0_tag;
  logic [PW0-1:0] s0_pay;
  logic [DW-1:0]  alu_z;

  logic           s1_live, s1_mask;
  logic [IDW-1:0] s1_tag;
  logic [DW-1:0]  s1_pay;

  logic           s2_v;
  logic [IDW-1:0] s2_tag;
  logic [DW-1:0]  s2_z;
  logic           s2_rdy;

  // fan-in: arbiter and winner select
  tfp_rr_arb #(.NP(NP), .IDW(IDW)) u_arb (
    .clk (clk),
    .rst (rst),
    .en  (adv),
    .req (in_valid),
    .gnt (gnt),
    .any (gnt_any),
    .idx (gnt_idx)
  );

  assign in_ready = gnt;

  always_comb begin
    sel_a    = '0;
    sel_b    = '0;
    sel_op   = '0;
    sel_mask = 1'b0;
    sel_stop = 1'b0;
    for (int k = 0; k < NP; k++) begin
      if (gnt_idx == IDW'(k)) begin
        sel_a    = in_a[k*DW +: DW];
        sel_b    = in_b[k*DW +: DW];
        sel_op   = in_op[k*OPW +: OPW];
        sel_mask = in_mask[k];
        sel_stop = in_stop[k];
      end
    end
  end

  // stage 0: operand capture, tagged with the winning port
  tfp_stage #(.NP(NP), .IDW(IDW), .PW(PW0)) u_s0 (
    .clk     (clk),
    .rst     (rst),
    .en      (adv),
    .stop    (in_stop),
    .in_live (gnt_any && !(sel_mask && sel_stop)),
    .in_tag  (gnt_idx),
    .in_mask (sel_mask),
    .in_pay  ({sel_op, sel_a, sel_b}),
    .live    (s0_live),
    .tag     (s0_tag),
    .mask    (s0_mask),
    .pay     (s0_pay)
  );

  tfp_alu #(.DW(DW)) u_alu (
    .op (s0_pay[PW0-1 -: OPW]),
    .a  (s0_pay[2*DW-1 -: DW]),
    .b  (s0_pay[DW-1:0]),
    .z  (alu_z)
  );

  // stage 1: computed result, still cancellable
  tfp_stage #(.NP(NP), .IDW(IDW), .PW(DW)) u_s1 (
    .clk     (clk),
    .rst     (rst),
    .en      (adv),
    .stop    (in_stop),
    .in_live (s0_live),
    .in_tag  (s0_tag),
    .in_mask (s0_mask),
    .in_pay  (alu_z),
    .live    (s1_live),
    .tag     (s1_tag),
    .mask    (s1_mask),
    .pay     (s1_pay)
  );

  // stage 2: committed output register
  always_comb begin
    s2_rdy = 1'b0;
    for (int k = 0; k < NP; k++) begin
      if (s2_tag == IDW'(k)) s2_rdy = out_ready[k];
    end
  end

  assign adv = !s2_v || s2_rdy;

  always_ff @(posedge clk) begin
    if (rst)      s2_v <= 1'b0;
    else if (adv) s2_v <= s1_live;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s2_tag <= s1_tag;
      s2_z   <= s1_pay;
    end
  end

  // fan-out: steer by tag
  for (genvar k = 0; k < NP; k++) begin : g_port
    assign out_valid[k]            = s2_v && (s2_tag == IDW'(k));
    assign out_z[k*DW +: DW]       = s2_z;
    assign out_tag[k*IDW +: IDW]   = s2_tag;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (out_valid[k] && !out_ready[k]) |=>
        (out_valid[k] && $stable(out_z[k*DW +: DW]))); // R7
    AST_TAG_MATCH: assert property (@(posedge clk) disable iff (rst)
      out_valid[k] |-> (out_tag[k*IDW +: IDW] == IDW'(k))); // R6
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0)); // R1
  AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid)); // R6
  AST_STALL_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (|(out_valid & ~out_ready)) |-> (in_ready == '0)); // R7
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0); // R2
  AST_UNMASKED_SURVIVES: assert property (@(posedge clk) disable iff (rst)
    (s1_live && !s1_mask && adv) |=> s2_v); // R10
endmodule

// File: tb/tagged_merge_pipe_bench.sv
`timescale 1ns/1ps
module tagged_merge_pipe_bench;
  localparam int NP  = 3;
  localparam int DW  = 8;
  localparam int IDW = 2;
  localparam int OW  = 2;
  localparam int QD  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [NP-1:0]     in_valid, in_ready, in_mask, in_stop;
  logic [NP*DW-1:0]  in_a, in_b;
  logic [NP*OW-1:0]  in_op;
  logic [NP-1:0]     out_valid, out_ready;
  logic [NP*DW-1:0]  out_z;
  logic [NP*IDW-1:0] out_tag;

  logic [NP-1:0]     drop;
  bit                chk_lat;
  int                n_tests = 0;
  int                n_fail  = 0;
  int                cyc     = 0;

  logic [DW-1:0]     q_z [NP][QD];
  int                q_e [NP][QD];
  int                hd [NP];
  int                tl [NP];
  int                fire_cnt [NP];
  int                mptr;
  logic [NP-1:0]     prev_hold;
  logic [NP*DW-1:0]  prev_z;

  tagged_merge_pipe #(.NP(NP), .DW(DW), .IDW(IDW)) u_tagged_merge_pipe (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op),
    .in_mask(in_mask), .in_stop(in_stop),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_z(out_z), .out_tag(out_tag)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] ref_z(input logic [1:0] op,
                                          input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a ^ b;
      default: return a & b;
    endcase
  endfunction

  // monitor: 3 ns after each falling edge, all signals settled
  initial begin
    mptr = 0;
    prev_hold = '0;
    prev_z = '0;
    forever begin
      @(negedge clk);
      #3;
      if (rst) begin
        mptr = 0;
        prev_hold = '0;
      end else begin
        automatic logic stalled;
        automatic logic [NP-1:0] egnt;
        automatic int win;
        stalled = |(out_valid & ~out_ready);
        egnt = '0;
        win = -1;
        if (!stalled) begin
          for (int o = 0; o < NP; o++) begin
            automatic int c;
            c = (mptr + o) % NP;
            if (win < 0 && in_valid[c]) win = c;
          end
          if (win >= 0) egnt[win] = 1'b1;
        end
        chk(in_ready == egnt, "R3", in_ready, egnt);
        chk($countones(in_ready) <= 1 && (in_ready & ~in_valid) == '0, "R2", in_ready, in_valid);
        if (stalled) chk(in_ready == '0, "R7", in_ready, 0);
        if (win >= 0) mptr = (win + 1) % NP;
        for (int k = 0; k < NP; k++) begin
          if (prev_hold[k])
            chk(out_valid[k] && out_z[k*DW +: DW] == prev_z[k*DW +: DW], "R7",
                out_z[k*DW +: DW], prev_z[k*DW +: DW]);
          if (out_valid[k])
            chk(out_tag[k*IDW +: IDW] == IDW'(k), "R6", out_tag[k*IDW +: IDW], k);
          if (out_valid[k] && out_ready[k]) begin
            fire_cnt[k]++;
            if (hd[k] == tl[k]) begin
              chk(1'b0, "R8", k, -1);
            end else begin
              chk(out_z[k*DW +: DW] == q_z[k][hd[k] % QD], "R4",
                  out_z[k*DW +: DW], q_z[k][hd[k] % QD]);
              if (chk_lat)
                chk(cyc + 1 == q_e[k][hd[k] % QD] + 3, "R5", cyc + 1, q_e[k][hd[k] % QD] + 3);
              hd[k]++;
            end
          end
          if (in_valid[k] && in_ready[k] && !drop[k]) begin
            q_z[k][tl[k] % QD] = ref_z(in_op[k*OW +: OW], in_a[k*DW +: DW], in_b[k*DW +: DW]);
            q_e[k][tl[k] % QD] = cyc + 1;
            tl[k]++;
          end
        end
        prev_hold = out_valid & ~out_ready;
        prev_z = out_z;
      end
    end
  end

  task automatic set_port(input int p, input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [1:0] op, input logic m, input logic s, input logic d);
    in_valid[p] = 1'b1;
    in_a[p*DW +: DW] = a;
    in_b[p*DW +: DW] = b;
    in_op[p*OW +: OW] = op;
    in_mask[p] = m;
    in_stop[p] = s;
    drop[p] = d;
  endtask

  task automatic clear_in();
    in_valid = '0;
    in_mask = '0;
    in_stop = '0;
    drop = '0;
  endtask

  // hold a request until granted; starts and ends just after a falling edge
  task automatic send(input int p, input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic [1:0] op, input logic m, input logic d);
    set_port(p, a, b, op, m, 1'b0, d);
    #3;
    while (!in_ready[p]) begin
      @(negedge clk);
      #3;
    end
    @(negedge clk);
    in_valid[p] = 1'b0;
    in_mask[p] = 1'b0;
    drop[p] = 1'b0;
  endtask

  task automatic drain_check();
    repeat (8) @(negedge clk);
    for (int k = 0; k < NP; k++)
      chk(hd[k] == tl[k], "R8", tl[k] - hd[k], 0);
  endtask

  logic [DW-1:0] bvals [7];
  int f0 [NP];

  initial begin
    bvals[0] = 8'h00; bvals[1] = 8'h01; bvals[2] = 8'h80; bvals[3] = 8'hff;
    bvals[4] = 8'h55; bvals[5] = 8'h33; bvals[6] = 8'h7f;
    for (int k = 0; k < NP; k++) begin
      hd[k] = 0; tl[k] = 0; fire_cnt[k] = 0;
    end
    rst = 1'b1;
    clear_in();
    in_a = '0; in_b = '0; in_op = '0;
    out_ready = '1;
    chk_lat = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    chk(out_valid == '0, "R1", out_valid, 0);
    chk(in_ready == '0, "R1", in_ready, 0);
    @(negedge clk);
    rst = 1'b0;

    // T1: arbitration, first all ports, then a shifting request pattern
    for (int k = 0; k < NP; k++) set_port(k, 8'(k + 1), 8'(3 * k), 2'(k), 1'b0, 1'b0, 1'b0);
    #3;
    chk(in_ready == 3'b001, "R1", in_ready, 1);
    @(negedge clk);
    repeat (11) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      automatic logic [NP-1:0] r;
      r = NP'((i * 5 + 3) % 8);
      clear_in();
      for (int k = 0; k < NP; k++)
        if (r[k]) set_port(k, 8'(i * 7 + k), 8'(i + 9), 2'((i + k) % 4), 1'b0, 1'b0, 1'b0);
      @(negedge clk);
    end
    clear_in();
    drain_check();

    // T2: sweep of operands and opcodes, one operation per edge, ports rotating
    begin
      automatic int n = 0;
      for (int ai = 0; ai < 16; ai++)
        for (int bi = 0; bi < 7; bi++)
          for (int op = 0; op < 4; op++) begin
            clear_in();
            set_port(n % NP, 8'(ai * 17), bvals[bi], 2'(op), 1'(n & 1), 1'b0, 1'b0);
            n++;
            @(negedge clk);
          end
    end
    clear_in();
    drain_check();

    // T3: stall on port 1, order and hold
    chk_lat = 1'b0;
    out_ready = 3'b101;
    fork
      begin
        send(1, 8'h10, 8'h01, 2'd0, 1'b0, 1'b0);
        send(0, 8'h20, 8'h02, 2'd1, 1'b0, 1'b0);
        send(1, 8'h30, 8'h0f, 2'd2, 1'b0, 1'b0);
        send(2, 8'h40, 8'hf0, 2'd3, 1'b0, 1'b0);
      end
      begin
        repeat (14) @(negedge clk);
        out_ready = '1;
      end
    join
    drain_check();

    // T4: cancellation with no stall
    chk_lat = 1'b1;
    for (int k = 0; k < NP; k++) f0[k] = fire_cnt[k];
    clear_in(); set_port(2, 8'h01, 8'h01, 2'd0, 1'b1, 1'b0, 1'b0); @(negedge clk); // reaches output reg
    clear_in(); set_port(2, 8'h02, 8'h01, 2'd0, 1'b1, 1'b0, 1'b1); @(negedge clk); // killed in stage 1
    clear_in(); set_port(0, 8'h03, 8'h01, 2'd0, 1'b1, 1'b0, 1'b0); @(negedge clk); // other port
    clear_in(); set_port(2, 8'h04, 8'h01, 2'd0, 1'b1, 1'b1, 1'b1); @(negedge clk); // killed on entry
    clear_in(); set_port(2, 8'h05, 8'h01, 2'd0, 1'b0, 1'b1, 1'b0); @(negedge clk); // unmasked
    clear_in(); set_port(2, 8'h06, 8'h01, 2'd0, 1'b1, 1'b0, 1'b0); @(negedge clk); // no stop
    clear_in();
    drain_check();
    chk(fire_cnt[2] - f0[2] == 3, "R9", fire_cnt[2] - f0[2], 3);
    chk(fire_cnt[0] - f0[0] == 1, "R10", fire_cnt[0] - f0[0], 1);

    // T5: cancellation while stalled
    chk_lat = 1'b0;
    for (int k = 0; k < NP; k++) f0[k] = fire_cnt[k];
    out_ready = 3'b110;
    clear_in(); set_port(0, 8'h11, 8'h22, 2'd0, 1'b0, 1'b0, 1'b0); @(negedge clk);
    clear_in(); set_port(1, 8'h33, 8'h22, 2'd1, 1'b1, 1'b0, 1'b1); @(negedge clk);
    clear_in(); set_port(2, 8'h44, 8'h22, 2'd2, 1'b1, 1'b0, 1'b0); @(negedge clk);
    clear_in();
    repeat (3) @(negedge clk);
    in_stop[1] = 1'b1;
    @(negedge clk);
    in_stop[1] = 1'b0;
    @(negedge clk);
    out_ready = '1;
    drain_check();
    chk(fire_cnt[1] - f0[1] == 0, "R9", fire_cnt[1] - f0[1], 0);
    chk(fire_cnt[0] - f0[0] == 1 && fire_cnt[2] - f0[2] == 1, "R10",
        fire_cnt[0] - f0[0] + fire_cnt[2] - f0[2], 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule